// File: doc/BRIEF.md
# Programmable Clock Rate Divider

This block divides a single input clock by a programmable integer and drives out the divided clock together with a one-cycle enable pulse that marks the last input cycle of each output period. The output is never gated. Software programs a divisor code through a simple write port and can read it back. The code lies in a field whose offset inside the control word is a parameter. A compile-time encoding sets how the code becomes a divisor. In the plus-one encoding the divisor is the code plus one. In the direct encoding the divisor equals the code. In the power-of-two encoding it is two raised to the code. In the table encoding the code indexes a parameter array.

Each write is validated before it is accepted. When no table is used, the decoded divisor must lie within a minimum and a maximum bound. When a table is used, a zero entry marks a forbidden code. A rejected write leaves the whole register untouched and raises a one-cycle error pulse. The control word also holds an autoidle bit at its own position, and a parameter sets its enable polarity.

The counter is a three-state machine. PASS means divide-by-1, where the output follows the input clock. HIGH is the first floor(N/2) cycles of a period. LOW is the rest of the period. HIGH moves to LOW when the in-period count reaches floor(N/2)-1. At the last cycle of a period (the tick), any state moves to PASS if the divisor waiting in the register is 1, and to HIGH otherwise. The divisor is only loaded on that transition.

Top module: `clk_rate_divider`

## Requirements
- R1: With the plus-one encoding, code k gives a divide ratio of k+1 (codes 0, 2 and 11 give 1, 3 and 12).
- R2: With the direct encoding, code k gives a ratio of k, and code 0 is rejected.
- R3: With the power-of-two encoding, code k gives a ratio of 2^k (codes 0, 1, 3 and 6 give 1, 2, 8 and 64).
- R4: With the table encoding, code k gives the table entry at index k (entry k occupies bits [k*DIV_W +: DIV_W] of DIV_TABLE). A code whose entry is zero is rejected.
- R5: Outside the table encoding, a code whose ratio is below MIN_DIV or above MAX_DIV is rejected.
- R6: The code field sits at bits [FIELD_LSB +: FIELD_W] of wr_data, and the autoidle bit sits at bit IDLE_BIT. A read returns both at those positions, and every other bit reads as 0.
- R7: autoidle_en equals the stored autoidle bit when IDLE_INV is 0, and its inverse when IDLE_INV is 1.
- R8: A rejected write changes neither the read value nor the output period. wr_err is 1 for exactly the one cycle after the write edge. An accepted write leaves wr_err at 0.
- R9: A new divisor takes effect only after the current output period has ended. A period that is running when a write arrives keeps its old length.
- R10: For a ratio N of 2 or more, tick is high once per N cycles, in the last cycle of the period, and clk_out is high for the first floor(N/2) cycles.
- R11: At ratio 1, tick is high in every cycle and clk_out follows clk_in.
- R12: After reset, the stored code is RST_CODE, the autoidle bit is 0, wr_err is 0, and the period matches the decoded RST_CODE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | REG_W | Control word being written |
| rd_data | output | REG_W | Stored code and autoidle bit at their positions, zeros elsewhere |
| clk_out | output | 1 | Divided clock |
| tick | output | 1 | High in the last input cycle of each output period |
| autoidle_en | output | 1 | Autoidle enable after the polarity is applied |
| wr_err | output | 1 | One-cycle pulse after a rejected write |

## Verification
The hardest case to reach is a write that lands part-way through a long period. To show the running period keeps its length, the stimulus first waits for a tick on a divide-by-12 setting. It then counts a few cycles, writes a short divisor, and counts on to the next tick, expecting twelve cycles in total. A single bench instantiates one copy of the block per encoding, so every encoding can be reached. Rejections then come from codes just past each bound, from code 0 in the direct encoding, and from zero table entries. Each rejection is followed by a fresh period measurement and a read-back.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;
    typedef enum logic [1:0] {
        ENC_PLUS1  = 2'd0,
        ENC_DIRECT = 2'd1,
        ENC_POW2   = 2'd2,
        ENC_TABLE  = 2'd3
    } cdiv_enc_e;

    typedef enum logic [1:0] {
        PH_PASS = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2
    } cdiv_phase_e;
endpackage

// File: rtl/cdiv_decode.sv
module cdiv_decode #(
    parameter int                  FIELD_W   = 4,
    parameter int                  DIV_W     = 8,
    parameter cdiv_pkg::cdiv_enc_e ENC       = cdiv_pkg::ENC_PLUS1,
    parameter int                  MIN_DIV   = 1,
    parameter int                  MAX_DIV   = 16,
    parameter logic [(2**FIELD_W)*DIV_W-1:0] DIV_TABLE = '0
) (
    input  logic [FIELD_W-1:0] code,
    output logic [DIV_W-1:0]   div,
    output logic               ok
);
    logic [31:0] raw;

    generate
        if (ENC == cdiv_pkg::ENC_TABLE) begin : g_table
            always_comb begin
                raw = 32'(DIV_TABLE[code*DIV_W +: DIV_W]);
                ok  = (raw != 32'd0);
            end
        end else begin : g_arith
            always_comb begin
                unique case (ENC)
                    cdiv_pkg::ENC_DIRECT: raw = 32'(code);
                    cdiv_pkg::ENC_POW2:   raw = 32'd1 << code;
                    default:              raw = 32'(code) + 32'd1;
                endcase
                ok = (raw >= 32'(MIN_DIV)) && (raw <= 32'(MAX_DIV)) && (raw != 32'd0);
            end
        end
    endgenerate

    assign div = raw[DIV_W-1:0];
endmodule

// File: rtl/cdiv_cfg_reg.sv
module cdiv_cfg_reg #(
    parameter int                  REG_W     = 32,
    parameter int                  FIELD_W   = 4,
    parameter int                  FIELD_LSB = 0,
    parameter int                  IDLE_BIT  = 31,
    parameter int                  DIV_W     = 8,
    parameter cdiv_pkg::cdiv_enc_e ENC       = cdiv_pkg::ENC_PLUS1,
    parameter int                  MIN_DIV   = 1,
    parameter int                  MAX_DIV   = 16,
    parameter int                  RST_CODE  = 0,
    parameter logic [(2**FIELD_W)*DIV_W-1:0] DIV_TABLE = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             idle_bit,
    output logic [DIV_W-1:0] div_reg,
    output logic [DIV_W-1:0] div_rst,
    output logic             wr_err
);
    localparam logic [FIELD_W-1:0] RST_FIELD = FIELD_W'(RST_CODE);

    logic [FIELD_W-1:0] code_q;
    logic [FIELD_W-1:0] wr_code;
    logic [DIV_W-1:0]   wr_div;
    logic               wr_ok;
    logic               rst_ok;

    assign wr_code = wr_data[FIELD_LSB +: FIELD_W];

    cdiv_decode #(
        .FIELD_W(FIELD_W), .DIV_W(DIV_W), .ENC(ENC),
        .MIN_DIV(MIN_DIV), .MAX_DIV(MAX_DIV), .DIV_TABLE(DIV_TABLE)
    ) u_dec_wr (
        .code(wr_code), .div(wr_div), .ok(wr_ok)
    );

    cdiv_decode #(
        .FIELD_W(FIELD_W), .DIV_W(DIV_W), .ENC(ENC),
        .MIN_DIV(MIN_DIV), .MAX_DIV(MAX_DIV), .DIV_TABLE(DIV_TABLE)
    ) u_dec_rst (
        .code(RST_FIELD), .div(div_rst), .ok(rst_ok)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q   <= RST_FIELD;
            idle_bit <= 1'b0;
            div_reg  <= div_rst;
            wr_err   <= 1'b0;
        end else begin
            wr_err <= wr_en && !wr_ok;
            if (wr_en && wr_ok) begin
                code_q   <= wr_code;
                idle_bit <= wr_data[IDLE_BIT];
                div_reg  <= wr_div;
            end
        end
    end

    always_comb begin
        rd_data                       = '0;
        rd_data[FIELD_LSB +: FIELD_W] = code_q;
        rd_data[IDLE_BIT]             = idle_bit;
    end

    logic unused_rst_ok;
    assign unused_rst_ok = rst_ok;
endmodule

// File: rtl/cdiv_phase_fsm.sv
module cdiv_phase_fsm #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_req,
    input  logic [DIV_W-1:0] div_rst,
    output logic             clk_out,
    output logic             tick,
    output logic [DIV_W-1:0] div_cur
);
    import cdiv_pkg::*;

    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    cdiv_phase_e       state, state_nxt;
    logic [DIV_W-1:0]  cnt, cnt_nxt;
    logic [DIV_W-1:0]  div_nxt;
    logic [DIV_W-1:0]  half;

    assign half = div_cur >> 1;
    assign tick = (cnt == div_cur - ONE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= (div_rst == ONE) ? PH_PASS : PH_HIGH;
            cnt     <= '0;
            div_cur <= div_rst;
        end else begin
            state   <= state_nxt;
            cnt     <= cnt_nxt;
            div_cur <= div_nxt;
        end
    end

    // transitions
    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt + ONE;
        div_nxt   = div_cur;
        if (tick) begin
            cnt_nxt   = '0;
            div_nxt   = div_req;
            state_nxt = (div_req == ONE) ? PH_PASS : PH_HIGH;
        end else begin
            unique case (state)
                PH_HIGH: if (cnt == half - ONE) state_nxt = PH_LOW;
                PH_LOW:  state_nxt = PH_LOW;
                default: state_nxt = state;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            PH_PASS: clk_out = clk;
            PH_HIGH: clk_out = 1'b1;
            default: clk_out = 1'b0;
        endcase
    end
endmodule

// File: rtl/clk_rate_divider.sv
module clk_rate_divider #(
    parameter int                  REG_W     = 32,
    parameter int                  FIELD_W   = 4,
    parameter int                  FIELD_LSB = 0,
    parameter int                  IDLE_BIT  = 31,
    parameter bit                  IDLE_INV  = 1'b0,
    parameter int                  DIV_W     = 8,
    parameter cdiv_pkg::cdiv_enc_e ENC       = cdiv_pkg::ENC_PLUS1,
    parameter int                  MIN_DIV   = 1,
    parameter int                  MAX_DIV   = 16,
    parameter int                  RST_CODE  = 0,
    parameter logic [(2**FIELD_W)*DIV_W-1:0] DIV_TABLE = '0
) (
    input  logic             clk_in,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             clk_out,
    output logic             tick,
    output logic             autoidle_en,
    output logic             wr_err
);
    logic             idle_bit;
    logic [DIV_W-1:0] div_reg;
    logic [DIV_W-1:0] div_rst;
    logic [DIV_W-1:0] div_cur;

    cdiv_cfg_reg #(
        .REG_W(REG_W), .FIELD_W(FIELD_W), .FIELD_LSB(FIELD_LSB),
        .IDLE_BIT(IDLE_BIT), .DIV_W(DIV_W), .ENC(ENC),
        .MIN_DIV(MIN_DIV), .MAX_DIV(MAX_DIV), .RST_CODE(RST_CODE),
        .DIV_TABLE(DIV_TABLE)
    ) u_cfg (
        .clk(clk_in), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .idle_bit(idle_bit), .div_reg(div_reg),
        .div_rst(div_rst), .wr_err(wr_err)
    );

    cdiv_phase_fsm #(.DIV_W(DIV_W)) u_fsm (
        .clk(clk_in), .rst_n(rst_n), .div_req(div_reg), .div_rst(div_rst),
        .clk_out(clk_out), .tick(tick), .div_cur(div_cur)
    );

    assign autoidle_en = idle_bit ^ IDLE_INV;
endmodule

// File: rtl/cdiv_checker.sv
module cdiv_checker #(
    parameter int REG_W    = 32,
    parameter int IDLE_BIT = 31,
    parameter bit IDLE_INV = 1'b0,
    parameter int DIV_W    = 8
) (
    input logic             clk_in,
    input logic             rst_n,
    input logic             wr_en,
    input logic [REG_W-1:0] rd_data,
    input logic             tick,
    input logic             autoidle_en,
    input logic             wr_err,
    input logic [DIV_W-1:0] div_cur
);
    // R9
    period_end_load_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
        (div_cur != $past(div_cur)) |-> $past(tick));

    // R8
    err_after_write_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
        wr_err |-> $past(wr_en));

    // R8
    reject_keeps_reg_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
        wr_err |-> $stable(rd_data));

    // R6
    reg_holds_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
        !$past(wr_en) |-> $stable(rd_data));

    // R11
    bypass_tick_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
        (div_cur == DIV_W'(1)) |-> tick);

    // R7
    idle_polarity_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
        autoidle_en == (rd_data[IDLE_BIT] ^ IDLE_INV));
endmodule

bind clk_rate_divider cdiv_checker #(
    .REG_W(REG_W), .IDLE_BIT(IDLE_BIT), .IDLE_INV(IDLE_INV), .DIV_W(DIV_W)
) u_cdiv_checker (
    .clk_in(clk_in), .rst_n(rst_n), .wr_en(wr_en), .rd_data(rd_data),
    .tick(tick), .autoidle_en(autoidle_en), .wr_err(wr_err), .div_cur(div_cur)
);

// File: tb/test_clk_rate_divider.sv
module test_clk_rate_divider;
    import cdiv_pkg::*;

    localparam int NI = 4;
    localparam int LSB_T[NI]  = '{4, 8, 0, 0};
    localparam int IDLE_T[NI] = '{0, 31, 8, 4};
    localparam bit INV_T[NI]  = '{1'b0, 1'b1, 1'b0, 1'b0};
    localparam int MIN_T[NI]  = '{1, 2, 1, 1};
    localparam int MAX_T[NI]  = '{12, 15, 64, 255};
    localparam int RST_T[NI]  = '{3, 5, 0, 0};
    localparam int RDIV_T[NI] = '{4, 5, 1, 4};
    localparam logic [1:0] ENC_T[NI] = '{2'd0, 2'd1, 2'd2, 2'd3};
    // code 0..15 -> 4,8,0,16,3,0,6,1,0,...
    localparam logic [127:0] TBL = {8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0,
                                    8'd1, 8'd6, 8'd0, 8'd3, 8'd16, 8'd0, 8'd8, 8'd4};

    typedef struct packed { int s; int code; int ok; int div; } vec_t;
    localparam int NV = 21;
    localparam vec_t VEC[NV] = '{
        '{0, 0, 1, 1}, '{0, 2, 1, 3}, '{0, 11, 1, 12}, '{0, 12, 0, 0}, '{0, 5, 1, 6},
        '{1, 1, 0, 0}, '{1, 0, 0, 0}, '{1, 2, 1, 2}, '{1, 15, 1, 15}, '{1, 7, 1, 7},
        '{2, 3, 1, 8}, '{2, 7, 0, 0}, '{2, 6, 1, 64}, '{2, 0, 1, 1}, '{2, 1, 1, 2},
        '{3, 2, 0, 0}, '{3, 3, 1, 16}, '{3, 7, 1, 1}, '{3, 5, 0, 0}, '{3, 4, 1, 3},
        '{3, 6, 1, 6}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NI-1:0]   wr_en = '0;
    logic [31:0]     wr_data = '0;
    logic [31:0]     rd[NI];
    logic [NI-1:0]   cko, tck, aen, err;
    int checks = 0, failures = 0, cycles = 0;
    int exp_div[NI], exp_code[NI];

    always #4 clk = ~clk;

    for (genvar g = 0; g < NI; g++) begin : g_dut
        clk_rate_divider #(
            .FIELD_LSB(LSB_T[g]), .IDLE_BIT(IDLE_T[g]), .IDLE_INV(INV_T[g]),
            .ENC(cdiv_enc_e'(ENC_T[g])), .MIN_DIV(MIN_T[g]), .MAX_DIV(MAX_T[g]),
            .RST_CODE(RST_T[g]), .DIV_TABLE(TBL)
        ) i_clk_rate_divider (
            .clk_in(clk), .rst_n(rst_n), .wr_en(wr_en[g]), .wr_data(wr_data),
            .rd_data(rd[g]), .clk_out(cko[g]), .tick(tck[g]),
            .autoidle_en(aen[g]), .wr_err(err[g])
        );
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
            summary();
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic measure(input int s, output int n, output int h);
        while (!tck[s]) step();
        n = 0; h = 0;
        do begin
            step();
            n++;
            if (cko[s]) h++;
        end while (!tck[s]);
    endtask

    task automatic wr(input int s, input logic [31:0] d, input int e, string req);
        wr_data  = d;
        wr_en[s] = 1'b1;
        step();
        wr_en[s] = 1'b0;
        chk({req, " wr_err pulse"}, int'(err[s]), e);
        step();
        chk({req, " wr_err one cycle"}, int'(err[s]), 0);
    endtask

    task automatic period(input int s, input int n_exp, string req);
        int n, h;
        measure(s, n, h);
        chk({req, " period"}, n, n_exp);
        chk({req, " high cycles R10"}, h, n_exp / 2);
    endtask

    initial begin
        int n;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R12 reset state
        for (int s = 0; s < NI; s++) begin
            chk("R12 rd_data", int'(rd[s]), RST_T[s] << LSB_T[s]);
            chk("R12 wr_err", int'(err[s]), 0);
            chk("R12 autoidle", int'(aen[s]), int'(INV_T[s]));
            period(s, RDIV_T[s], "R12");
            exp_div[s] = RDIV_T[s];
            exp_code[s] = RST_T[s];
        end

        // vector table: R1..R5, R8, R10
        for (int v = 0; v < NV; v++) begin
            int s;
            string tag;
            s = VEC[v].s;
            tag = (s == 0) ? "R1" : (s == 1) ? "R2" : (s == 2) ? "R3" : "R4";
            if (!VEC[v].ok) tag = {tag, "/R5/R8"};
            wr(s, 32'(VEC[v].code) << LSB_T[s], VEC[v].ok ? 0 : 1, tag);
            if (VEC[v].ok) begin
                exp_div[s] = VEC[v].div;
                exp_code[s] = VEC[v].code;
            end
            chk({tag, " R6 read"}, int'(rd[s]), exp_code[s] << LSB_T[s]);
            period(s, exp_div[s], tag);
        end

        // R6 stray bits read as zero, R7 polarity
        wr(0, 32'hFFFF_FF1F, 0, "R6");
        chk("R6 read masked", int'(rd[0]), 32'h11);
        chk("R7 autoidle plain", int'(aen[0]), 1);
        wr(1, 32'h8000_0200, 0, "R7");
        chk("R7 read idle bit", int'(rd[1]), 32'h8000_0200);
        chk("R7 autoidle inverted", int'(aen[1]), 0);

        // R9 write in the middle of a long period
        wr(0, 32'(11) << 4, 0, "R9");
        period(0, 12, "R9 setup");
        n = 3;
        repeat (3) step();
        wr_data = 32'(1) << 4;
        wr_en[0] = 1'b1;
        step();
        wr_en[0] = 1'b0;
        n++;
        while (!tck[0]) begin
            step();
            n++;
        end
        chk("R9 running period kept", n, 12);
        period(0, 2, "R9 new");

        // R11 divide by one
        wr(2, 32'h0, 0, "R11");
        period(2, 1, "R11");
        for (int k = 0; k < 3; k++) begin
            chk("R11 tick each cycle", int'(tck[2]), 1);
            chk("R11 clk_out low phase", int'(cko[2]), 0);
            @(posedge clk);
            #1;
            chk("R11 clk_out high phase", int'(cko[2]), 1);
            step();
        end
        summary();
    end
endmodule